// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It takes a stream of oscillator events, given as a one-cycle enable on the system clock, and emits one feedback pulse toward the phase detector for every 2·(32·M + S) events. The first stage halves the event rate. A digital model of a dual-modulus prescaler then divides the halved stream by 33 or by 32. A main counter loaded with M and a swallow counter loaded with S choose the modulus: the prescaler divides by 33 while the swallow count is non-zero and by 32 for the rest of the main count.

The M and S words come from the control interface and may change at any time. The divider takes them in only at the boundary of a complete division cycle, and only when S is smaller than M. A word pair that breaks this rule raises an error flag, and the divider keeps running on the last accepted ratio. A synchronous reset loads the counters straight from the words present at that moment and starts a fresh cycle.

Top module: `pulse_swallow_div`

## Requirements
- R1: `fb_pulse` is high for exactly one clock cycle per division cycle. It rises on the clock edge that registers the 2·(32·M+S)-th enabled `osc_en` event of the cycle.
- R2: Clock cycles in which `osc_en` is low do not advance the divider. The pulse spacing is counted in enabled events only, whatever the gaps between them.
- R3: After k enabled events into a cycle, `mod_ctl` is high (1 = divide by 33) exactly when floor(k/2) < 33·S. When S = 0 it stays low for the whole cycle.
- R4: A change of `m_word` or `s_word` in the middle of a cycle has no effect on that cycle. The new pair takes effect from the next cycle boundary.
- R5: `ratio_err` is high in the cycle after any clock edge at which `s_word` ≥ `m_word`. An offending pair is never loaded, and the previous ratio continues.
- R6: At a clock edge with `rst` high, the divider loads a valid `m_word`/`s_word` pair directly. If the pair is invalid, it loads M = RST_M (default 1) and S = 0. `fb_pulse` is then low, and `mod_ctl` equals (S ≠ 0).
- R7: The extreme ratios M = 1, S = 0 (64 events) and M = 1023, S = 31 (65534 events) divide correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One oscillator event per high cycle |
| m_word | input | M_W (10) | Main division ratio M |
| s_word | input | S_W (5) | Swallow count S |
| fb_pulse | output | 1 | One-cycle feedback pulse per division cycle |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by 33 |
| ratio_err | output | 1 | Programmed S is not smaller than M |

## Verification
The divider is first driven with a continuous event stream at a small ratio, which fixes both the pulse period and the point where the modulus switches. A random-gap stream at the same ratio separates counting enabled events from counting clocks. A ratio change written partway through a cycle shows whether the load waits for the boundary. Invalid pairs, a reset with an invalid pair, and the smallest and largest ratios show whether an error holds the old ratio and whether the counter widths are right at their ends.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // prescaler modulus selection
    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } modsel_e;

    typedef struct packed {
        logic tgl;
    } half_st_t;

endpackage

// File: rtl/psd_half.sv
module psd_half
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    output logic half_tick
);

    half_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.tgl = 1'b0;
        else if (osc_en)
            st_d.tgl = ~st_q.tgl;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign half_tick = osc_en & st_q.tgl;

    // R2: with no event the phase of the halving stage must not move
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(st_q.tgl));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int S_W = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    half_tick,
    input  modsel_e mod_sel,
    output logic    pre_tick
);

    localparam int PRE_LOW = 1 << S_W;
    localparam int CNT_W   = S_W + 1;
    localparam logic [CNT_W-1:0] LAST_LOW  = CNT_W'(PRE_LOW - 1);
    localparam logic [CNT_W-1:0] LAST_HIGH = CNT_W'(PRE_LOW);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val = (mod_sel == MOD_HIGH) ? LAST_HIGH : LAST_LOW;
        pre_tick = half_tick && (cnt_q == last_val);
        cnt_d    = cnt_q;
        if (rst)
            cnt_d = '0;
        else if (pre_tick)
            cnt_d = '0;
        else if (half_tick)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    // R3: the count never exceeds the longer modulus
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_HIGH);

    // R3: in the short-modulus phase the count stays within 32 states
    a_r3_low_phase: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == MOD_LOW) |-> (cnt_q <= LAST_LOW));

endmodule

// File: rtl/psd_counters.sv
module psd_counters
    import psd_pkg::*;
#(
    parameter int M_W   = 10,
    parameter int S_W   = 5,
    parameter int RST_M = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_tick,
    input  logic [M_W-1:0] m_word,
    input  logic [S_W-1:0] s_word,
    output modsel_e        mod_sel,
    output logic           fb_pulse,
    output logic           ratio_err
);

    localparam logic [M_W-1:0] FALLBACK_M = M_W'(RST_M);

    typedef struct packed {
        logic [M_W-1:0] m_act;
        logic [S_W-1:0] s_act;
        logic [M_W-1:0] main_cnt;
        logic [S_W-1:0] swal_cnt;
        logic           fb;
        logic           err;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    in_ok;
    logic    cycle_end;
    logic [M_W-1:0] s_ext;

    always_comb begin
        s_ext     = {{(M_W - S_W){1'b0}}, s_word};
        in_ok     = s_ext < m_word;
        cycle_end = pre_tick && (st_q.main_cnt == M_W'(1));
        st_d      = st_q;
        st_d.err  = ~in_ok;
        st_d.fb   = 1'b0;
        if (rst) begin
            if (in_ok) begin
                st_d.m_act = m_word;
                st_d.s_act = s_word;
            end else begin
                st_d.m_act = FALLBACK_M;
                st_d.s_act = '0;
            end
            st_d.main_cnt = st_d.m_act;
            st_d.swal_cnt = st_d.s_act;
        end else if (cycle_end) begin
            st_d.fb = 1'b1;
            if (in_ok) begin
                st_d.m_act = m_word;
                st_d.s_act = s_word;
            end
            st_d.main_cnt = st_d.m_act;
            st_d.swal_cnt = st_d.s_act;
        end else if (pre_tick) begin
            st_d.main_cnt = st_q.main_cnt - 1'b1;
            if (st_q.swal_cnt != '0)
                st_d.swal_cnt = st_q.swal_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mod_sel   = (st_q.swal_cnt != '0) ? MOD_HIGH : MOD_LOW;
    assign fb_pulse  = st_q.fb;
    assign ratio_err = st_q.err;

    // R5: only pairs with S below M are ever running
    a_r5_swallow_below_main: assert property (@(posedge clk) disable iff (rst)
        {{(M_W - S_W){1'b0}}, st_q.swal_cnt} < st_q.main_cnt);

    // R4: the accepted ratio is frozen inside a cycle
    a_r4_hold_midcycle: assert property (@(posedge clk) disable iff (rst)
        !(pre_tick && (st_q.main_cnt == M_W'(1)))
        |=> ($stable(st_q.m_act) && $stable(st_q.s_act)));

    // R1: a feedback pulse lasts a single cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        st_q.fb |=> !st_q.fb);

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int M_W   = 10,
    parameter int S_W   = 5,
    parameter int RST_M = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           osc_en,
    input  logic [M_W-1:0] m_word,
    input  logic [S_W-1:0] s_word,
    output logic           fb_pulse,
    output logic           mod_ctl,
    output logic           ratio_err
);

    logic    half_tick;
    logic    pre_tick;
    modsel_e mod_sel;

    psd_half u_half (
        .clk       (clk),
        .rst       (rst),
        .osc_en    (osc_en),
        .half_tick (half_tick)
    );

    psd_prescaler #(.S_W(S_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .mod_sel   (mod_sel),
        .pre_tick  (pre_tick)
    );

    psd_counters #(.M_W(M_W), .S_W(S_W), .RST_M(RST_M)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pre_tick  (pre_tick),
        .m_word    (m_word),
        .s_word    (s_word),
        .mod_sel   (mod_sel),
        .fb_pulse  (fb_pulse),
        .ratio_err (ratio_err)
    );

    assign mod_ctl = (mod_sel == MOD_HIGH);

    // R3: a pulse (cycle start) with S = 0 accepted never enters the long modulus
    a_r3_pulse_no_mod_when_s0: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse && $past(s_word) == '0 && !ratio_err) |-> !mod_ctl);

endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic [9:0] m_word = 10'd3;
    logic [4:0] s_word = 5'd2;
    logic       fb_pulse, mod_ctl, ratio_err;

    int    n_checks = 0;
    int    n_err = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R6";

    // reference model state
    int m_cur = 1, s_cur = 0, k = 0;
    bit e_fb = 0, e_mod = 0, e_err = 0, m_live = 0;

    always #4 clk = ~clk;

    pulse_swallow_div dut (
        .clk(clk), .rst(rst), .osc_en(osc_en),
        .m_word(m_word), .s_word(s_word),
        .fb_pulse(fb_pulse), .mod_ctl(mod_ctl), .ratio_err(ratio_err)
    );

    // behavioural model: counts enabled events against 2*(32M+S)
    always @(posedge clk) begin
        bit ok;
        ok = (int'(s_word) < int'(m_word));
        e_err = !ok;
        e_fb  = 1'b0;
        if (rst) begin
            if (ok) begin m_cur = int'(m_word); s_cur = int'(s_word); end
            else    begin m_cur = 1; s_cur = 0; end
            k = 0;
            m_live = 1'b1;
        end else if (osc_en) begin
            k++;
            if (k == 2 * (32 * m_cur + s_cur)) begin
                e_fb = 1'b1;
                k = 0;
                if (ok) begin m_cur = int'(m_word); s_cur = int'(s_word); end
            end
        end
        e_mod = ((k / 2) < 33 * s_cur);
        cyc++;
    end

    task automatic chk(input string req, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (%s) cycle %0d: actual=%0b expected=%0b", req, tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_live && !done) begin
            chk("R1 fb_pulse", fb_pulse, e_fb);
            chk("R3 mod_ctl", mod_ctl, e_mod);
            chk("R5 ratio_err", ratio_err, e_err);
        end
    end

    task automatic run(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            osc_en = (pct >= 100) ? 1'b1 : (($urandom % 100) < pct);
        end
    endtask

    task automatic set_ratio(input int m, input int s);
        @(posedge clk); #1;
        m_word = 10'(m);
        s_word = 5'(s);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst = 1'b1; osc_en = 1'b0;
        @(posedge clk); #1; rst = 1'b0;
    endtask

    initial begin
        // R6: reset with a valid pair loads it directly
        tag = "R6"; osc_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1/R3: continuous events, M=3 S=2 (period 196)
        tag = "R1"; run(800, 100);
        // R2: gaps in the event stream
        tag = "R2"; run(1500, 45);
        // R4: change the ratio partway through a cycle
        tag = "R4"; run(57, 100); set_ratio(6, 5); run(1200, 100);
        set_ratio(2, 1); run(30, 70); set_ratio(5, 0); run(1500, 80);
        // R5: invalid pairs raise the flag and the old ratio continues
        tag = "R5"; set_ratio(4, 4); run(900, 100);
        set_ratio(0, 0); run(700, 100); set_ratio(3, 31); run(400, 60);
        // R6: reset with an invalid pair falls back to M=1 S=0
        tag = "R6"; set_ratio(2, 7); do_reset(); run(300, 100);
        // R7: smallest ratio
        tag = "R7"; set_ratio(1, 0); run(400, 100);
        // R7: largest ratio, one full cycle of 65534 events
        set_ratio(1023, 31); run(70, 100); do_reset(); run(65600, 100);
        set_ratio(33, 31); run(5000, 100);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 190000; w++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule